// File: doc/BRIEF.md
# Dual-Path Latched/Registered Bus Transceiver

This block moves 18-bit words between two buses, called A and B. It has two independent paths, A-to-B and B-to-A. Each path has its own drive enable, pass-through control and capture strobe. While the pass-through control is high, the path is transparent: the destination follows the source in the same cycle. While it is low, the path shows a stored word. That word changes only when the path's capture strobe rises.

Storage in each path is a master/slave pair. The master stage tracks the source while the strobe is low. The slave stage takes the master's content on a rising strobe. As a result, the captured word is the one present while the strobe was still low, not one that appears together with the rise.

The capture strobes are ordinary inputs sampled on the system clock `clk`. A rise is a strobe seen high at one `clk` edge after being seen low at the previous edge. The bidirectional pins sit outside the block. Each side presents a data-out vector and a per-bit drive vector for an external tristate buffer. The A-to-B drive enable is active high and the B-to-A drive enable is active low.

Top module: `dual_path_xcvr`

## Requirements
- R1: While a path's pass-through control is high and the path is driving, its destination output equals its source input in the same cycle, with no clock edge needed.
- R2: With pass-through low, a `clk` edge at which the path's strobe is sampled high, after being sampled low at the previous edge, loads the stored word. The destination shows it from that edge on. The word loaded is the source value sampled at the last `clk` edge where the strobe was low.
- R3: With pass-through low and no strobe rise, the destination keeps its stored word whatever the source does.
- R4: When pass-through falls while the strobe is low, the destination keeps the last word passed through. The next strobe rise loads the source value tracked while the strobe was low.
- R5: If the source changes in the same cycle that the strobe rises, the older value (held while the strobe was low) is loaded, not the new one.
- R6: The A-to-B enable is active high. At 1, `b_drv` is all ones. At 0, `b_drv` and `b_out` are all zeros.
- R7: The B-to-A enable is active low. At 0, `a_drv` is all ones. At 1, `a_drv` and `a_out` are all zeros.
- R8: A path whose drive is off still stores. A word captured while the drive is off appears at once when the drive is turned back on.
- R9: Synchronous active-high reset clears both stored words, so after reset, with pass-through low and the drive on, both outputs read zero.
- R10: The two paths are independent. Activity on one path's controls or source leaves the other path's output unchanged.
- R11: Every path is 18 bits wide with true polarity. Alternating bit patterns pass and store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Word seen on the A bus pins |
| a_out | output | 18 | Word to drive onto the A bus (zero when not driving) |
| a_drv | output | 18 | Per-bit drive enable for the A bus buffer |
| b_in | input | 18 | Word seen on the B bus pins |
| b_out | output | 18 | Word to drive onto the B bus (zero when not driving) |
| b_drv | output | 18 | Per-bit drive enable for the B bus buffer |
| ab_en | input | 1 | A-to-B drive enable, active high |
| ab_pass | input | 1 | A-to-B pass-through control |
| ab_tick | input | 1 | A-to-B capture strobe |
| ba_en_n | input | 1 | B-to-A drive enable, active low |
| ba_pass | input | 1 | B-to-A pass-through control |
| ba_tick | input | 1 | B-to-A capture strobe |

## Verification
A wrong master stage is only visible on the next strobe rise. It shows as the new source word, rather than the word held while the strobe was low, appearing one `clk` edge after the rise. A corrupted slave stage shows on the destination as soon as pass-through is low and the drive is on, with no edge needed. Because a disabled path forces its outputs to zero, a storage fault during a disabled interval only appears on the first cycle after the drive returns. The bench therefore re-enables the path and reads it immediately.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int unsigned XCVR_W = 18;

    // What a path's storage does at the next clk edge
    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,
        MODE_HOLD    = 2'd1,
        MODE_CAPTURE = 2'd2
    } path_mode_e;

    // Per-path control bundle
    typedef struct packed {
        logic en_raw;   // drive enable as seen at the pin
        logic pass;     // pass-through control
        logic tick;     // capture strobe
    } path_ctl_t;

    // Convert a pin-level enable to an active-true flag
    function automatic logic en_active(input logic raw, input bit low_true);
        return low_true ? ~raw : raw;
    endfunction

    // Storage action chosen from the pass-through level and strobe rise
    function automatic path_mode_e pick_mode(input logic pass, input logic rise);
        if (pass)
            return MODE_PASS;
        else if (rise)
            return MODE_CAPTURE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_tick_edge.sv
module xcvr_tick_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic rise
);
    logic seen_q;

    // Reset to "high" so a strobe already high after reset is not a rise
    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b1;
        else     seen_q <= tick;
    end

    assign rise = tick & ~seen_q;

    // R2
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pass,
    input  logic         tick,
    input  logic         rise,
    input  logic [W-1:0] src,
    output logic [W-1:0] held
);
    logic [W-1:0] master_q;
    logic [W-1:0] slave_q;
    path_mode_e   mode;

    assign mode = pick_mode(pass, rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= '0;
            slave_q  <= '0;
        end else begin
            unique case (mode)
                MODE_PASS: begin
                    master_q <= src;
                    slave_q  <= src;
                end
                MODE_CAPTURE: begin
                    slave_q  <= master_q;
                end
                MODE_HOLD: begin
                    if (!tick) master_q <= src;
                end
                default: begin
                    master_q <= master_q;
                end
            endcase
        end
    end

    assign held = slave_q;

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && !pass) |=> (slave_q == $past(master_q)));

    // R3
    slave_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!pass && !rise) |=> $stable(slave_q));

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (slave_q == '0 && master_q == '0));

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int unsigned W        = XCVR_W,
    parameter bit          LOW_TRUE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  path_ctl_t    ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst,
    output logic [W-1:0] drv
);
    logic         rise;
    logic         en;
    logic [W-1:0] held;
    logic [W-1:0] view;

    xcvr_tick_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .tick (ctl.tick),
        .rise (rise)
    );

    xcvr_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .pass (ctl.pass),
        .tick (ctl.tick),
        .rise (rise),
        .src  (src),
        .held (held)
    );

    assign en   = en_active(ctl.en_raw, LOW_TRUE);
    assign view = ctl.pass ? src : held;
    assign dst  = en ? view : '0;
    assign drv  = {W{en}};

    // R6 R7
    drv_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (drv == '0) || (drv == '1));

    // R6 R7
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (drv == '0) |-> (dst == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pass && $past(!ctl.pass) && !$past(rise) && en && $past(en)
         && !$past(rst)) |-> $stable(dst));

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drv,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drv,
    input  logic         ab_en,
    input  logic         ab_pass,
    input  logic         ab_tick,
    input  logic         ba_en_n,
    input  logic         ba_pass,
    input  logic         ba_tick
);
    localparam int unsigned NPATH = 2;   // index 0: A to B, index 1: B to A

    path_ctl_t    ctl_v [NPATH];
    logic [W-1:0] src_v [NPATH];
    logic [W-1:0] dst_v [NPATH];
    logic [W-1:0] drv_v [NPATH];

    assign ctl_v[0] = '{en_raw: ab_en,   pass: ab_pass, tick: ab_tick};
    assign ctl_v[1] = '{en_raw: ba_en_n, pass: ba_pass, tick: ba_tick};
    assign src_v[0] = a_in;
    assign src_v[1] = b_in;

    for (genvar d = 0; d < NPATH; d++) begin : g_path
        xcvr_lane #(
            .W        (W),
            .LOW_TRUE (d == 1)
        ) u_lane (
            .clk (clk),
            .rst (rst),
            .ctl (ctl_v[d]),
            .src (src_v[d]),
            .dst (dst_v[d]),
            .drv (drv_v[d])
        );
    end

    assign b_out = dst_v[0];
    assign b_drv = drv_v[0];
    assign a_out = dst_v[1];
    assign a_drv = drv_v[1];

endmodule

// File: tb/sim_dual_path_xcvr.sv
`timescale 1ns/1ps
module sim_dual_path_xcvr;
    localparam int W = 18;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_drv, b_out, b_drv;
    logic ab_en = 1'b1, ab_pass = 1'b0, ab_tick = 1'b1;
    logic ba_en_n = 1'b0, ba_pass = 1'b0, ba_tick = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_path_xcvr u0 (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .ab_en(ab_en), .ab_pass(ab_pass), .ab_tick(ab_tick),
        .ba_en_n(ba_en_n), .ba_pass(ba_pass), .ba_tick(ba_tick)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        a_in = 18'h3FFFF; b_in = 18'h2F0F0;
        rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
        chk("R9 b_out after reset", b_out, '0);
        chk("R9 a_out after reset", a_out, '0);
        chk("R6 b_drv enabled", b_drv, ONES);
        chk("R7 a_drv enabled", a_drv, ONES);
    endtask

    task automatic t_transparent;
        ab_pass = 1'b1; a_in = 18'h12345; #1;
        chk("R1 same-cycle pass", b_out, 18'h12345);
        a_in = 18'h0BEEF; #1;
        chk("R1 follows change", b_out, 18'h0BEEF);
        ba_pass = 1'b1; b_in = 18'h2AAAA; #1;
        chk("R11 B-to-A pattern", a_out, 18'h2AAAA);
        b_in = 18'h15555; #1;
        chk("R11 B-to-A inverse pattern", a_out, 18'h15555);
        ba_pass = 1'b0; cyc(1);
    endtask

    task automatic t_hold;
        // strobe high, pass P, then drop pass
        ab_tick = 1'b1; ab_pass = 1'b1; a_in = 18'h00AAA; cyc(2);
        ab_pass = 1'b0; cyc(1);
        a_in = 18'h3C3C3; cyc(3);
        chk("R3 hold against source change", b_out, 18'h00AAA);
    endtask

    task automatic t_clocked;
        ab_tick = 1'b0; a_in = 18'h2AAAA; cyc(2);
        chk("R3 no capture while strobe low", b_out, 18'h00AAA);
        ab_tick = 1'b1; #1;
        chk("R2 no change before edge", b_out, 18'h00AAA);
        cyc(1);
        chk("R2 captured after rise", b_out, 18'h2AAAA);
        chk("R11 stored pattern", b_out, 18'h2AAAA);
        a_in = 18'h11111; cyc(2);
        chk("R3 strobe steady high", b_out, 18'h2AAAA);
    endtask

    task automatic t_master_age;
        ab_tick = 1'b0; a_in = 18'h0F0F0; cyc(2);
        a_in = 18'h30303; ab_tick = 1'b1; cyc(1);
        chk("R5 older value captured", b_out, 18'h0F0F0);
    endtask

    task automatic t_fall_low;
        ab_tick = 1'b0; ab_pass = 1'b1; a_in = 18'h0ABCD; cyc(2);
        ab_pass = 1'b0; cyc(1);
        a_in = 18'h1DCBA; cyc(2);
        chk("R4 hold after pass falls with strobe low", b_out, 18'h0ABCD);
        ab_tick = 1'b1; cyc(1);
        chk("R4 rise loads tracked value", b_out, 18'h1DCBA);
    endtask

    task automatic t_enables;
        ab_en = 1'b0; #1;
        chk("R6 b_drv off", b_drv, '0);
        chk("R6 b_out quiet", b_out, '0);
        ab_en = 1'b1; #1;
        chk("R6 b_drv back on", b_drv, ONES);
        ba_en_n = 1'b1; #1;
        chk("R7 a_drv off when high", a_drv, '0);
        chk("R7 a_out quiet", a_out, '0);
        ba_en_n = 1'b0; #1;
        chk("R7 a_drv on when low", a_drv, ONES);
        cyc(1);
    endtask

    task automatic t_disabled_store;
        ab_en = 1'b0; ab_tick = 1'b0; a_in = 18'h24680; cyc(2);
        ab_tick = 1'b1; cyc(1);
        chk("R8 quiet while capturing", b_out, '0);
        ab_en = 1'b1; #1;
        chk("R8 capture while disabled", b_out, 18'h24680);
        cyc(1);
    endtask

    task automatic t_independent;
        // B-to-A holds; exercise A-to-B heavily
        ba_pass = 1'b1; b_in = 18'h13579; cyc(2);
        ba_pass = 1'b0; ba_tick = 1'b1; cyc(1);
        b_in = 18'h3FFFF;
        ab_pass = 1'b1; a_in = 18'h00001; cyc(1);
        ab_pass = 1'b0; ab_tick = 1'b0; cyc(2); ab_tick = 1'b1; cyc(1);
        chk("R10 A-to-B activity leaves a_out", a_out, 18'h13579);
        // B-to-A capture leaves b_out
        ba_tick = 1'b0; cyc(2); ba_tick = 1'b1; cyc(1);
        chk("R10 B-to-A capture", a_out, 18'h3FFFF);
        chk("R10 b_out untouched", b_out, 18'h00001);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_hold();
        t_clocked();
        t_master_age();
        t_fall_low();
        t_enables();
        t_disabled_store();
        t_independent();
        done = 1'b1;
        summary();
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule